// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two 32-bit binary floating-point words and returns the rounded 32-bit result with overflow, underflow and invalid flags. Each word has a sign bit in bit 31, an 8-bit exponent field in bits 30:23 with bias 127, and a 23-bit fraction in bits 22:0. Normal values carry an implied leading one. An exponent field of zero stands for zero or, with a nonzero fraction, a denormal with no implied one and a scale of 2^-126. An exponent field of 255 stands for infinity when the fraction is zero and for NaN otherwise.

Operations enter on a valid/ready stream. A beat is taken on any rising edge where `in_valid` and `in_ready` are both high. Results leave on a second valid/ready stream. A result stays on the output until the edge where `out_valid` and `out_ready` are both high. When the output is held, the two internal stages fill and `in_ready` falls, so back-pressure reaches the producer with no loss. The first stage unpacks the operands, orders them by magnitude, aligns the smaller one and adds or subtracts. The second stage normalizes, rounds to nearest with ties to even, and packs the result.

Top module: `fpadd_sp`

## Requirements
- R1: An operation is accepted on each rising edge with `in_valid` and `in_ready` high. Results are delivered in acceptance order, exactly one per edge with `out_valid` and `out_ready` high.
- R2: While `out_ready` is high, `in_ready` is high, and each result appears on the output two cycles after the edge that accepted it.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, the result word and all three flags keep their values on the next cycle.
- R4: For finite operands, the result is the exact value of A + B (or A - B when `in_sub` is 1) rounded to a 24-bit significand with round-to-nearest, ties to even.
- R5: Rounding accounts for every bit of the smaller operand, including bits shifted far past the result's last place. A sum exactly halfway between two neighbours rounds to the even one. A sum slightly above halfway rounds up.
- R6: Denormal operands are added without an implied one. A nonzero finite result too small for a normal exponent is returned with exponent field 0. Only such a result sets `out_udf`.
- R7: An exact zero result is 0x00000000, except when both effective operand signs are negative, in which case it is 0x80000000. All flags are clear in both cases.
- R8: A finite result whose rounded biased exponent reaches 255 is returned as infinity with the result's sign, with `out_ovf` set and the other flags clear.
- R9: If either operand is a NaN, the result is 0x7FC00000 with all flags clear.
- R10: An infinite operand plus a finite one, or plus an infinity of the same effective sign, returns that infinity with no flags. Two infinities of opposite effective sign return 0x7FC00000 with `out_inv` set.
- R11: A round-up that carries out of the significand gives a significand of 1.0 and raises the exponent by one.
- R12: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation beat present |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_sub | input | 1 | 1 selects A - B, 0 selects A + B |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sum | output | 32 | Rounded result word |
| out_ovf | output | 1 | Result overflowed to infinity |
| out_udf | output | 1 | Result is a nonzero denormal |
| out_inv | output | 1 | Infinities of opposite sign were combined |

## Verification
Each result and its flags are due two cycles after the accepting edge when the consumer is always ready. Under back-pressure a result can be due later, but never earlier and never out of order. The bench notes the cycle count at each acceptance and queues the value its own exact-arithmetic model predicts. It compares outputs only in the middle of the low clock phase. Each time a result is taken, it compares the head of the queue with the output and, in the always-ready phase, checks the two-cycle gap. A beat held by back-pressure is also checked to stay unchanged on the next sample.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned GRS_W  = 3;
  localparam int unsigned MANT_W = FRAC_W + 1;
  localparam int unsigned EXT_W  = MANT_W + GRS_W;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;

  localparam logic [EXP_W-1:0]  EXP_MAX = '1;
  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // one operand after field decode
  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp_eff;
    logic [MANT_W-1:0] mant;
    logic              is_inf;
    logic              is_nan;
  } opnd_t;

  // state carried from the add stage to the round stage
  typedef struct packed {
    logic              special;
    logic [WORD_W-1:0] special_word;
    logic              special_inv;
    logic              sign;
    logic              zero_sign;
    logic [EXP_W-1:0]  exp_base;
    logic [EXT_W:0]    sum;
  } mid_t;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack import fpadd_pkg::*; (
  input  logic [WORD_W-1:0] word,
  input  logic              flip,
  output opnd_t             opnd
);
  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] fr;
  logic              ef_zero;

  always_comb begin
    ef      = word[WORD_W-2 -: EXP_W];
    fr      = word[FRAC_W-1:0];
    ef_zero = (ef == '0);
    opnd.sign    = word[WORD_W-1] ^ flip;
    opnd.is_nan  = (ef == EXP_MAX) && (fr != '0);
    opnd.is_inf  = (ef == EXP_MAX) && (fr == '0);
    // denormals and zero live at the minimum normal scale, no hidden one
    opnd.exp_eff = ef_zero ? EXP_W'(1) : ef;
    opnd.mant    = {!ef_zero, fr};
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align import fpadd_pkg::*; (
  input  opnd_t op_x,
  input  opnd_t op_y,
  output mid_t  mid
);
  localparam int unsigned SH_W = $clog2(EXT_W + 1);

  logic              swap;
  logic              big_sign, lit_sign, eff_sub, any_nan, inf_clash;
  logic [EXP_W-1:0]  big_exp, lit_exp, gap;
  logic [MANT_W-1:0] big_mant, lit_mant;
  logic [SH_W-1:0]   gap_sat;
  logic [EXT_W-1:0]  big_ext, lit_ext, lit_al;
  logic [2*EXT_W-1:0] shwin;

  always_comb begin
    // order by magnitude so the subtraction never goes negative
    swap     = {op_y.exp_eff, op_y.mant} > {op_x.exp_eff, op_x.mant};
    big_sign = swap ? op_y.sign    : op_x.sign;
    lit_sign = swap ? op_x.sign    : op_y.sign;
    big_exp  = swap ? op_y.exp_eff : op_x.exp_eff;
    lit_exp  = swap ? op_x.exp_eff : op_y.exp_eff;
    big_mant = swap ? op_y.mant    : op_x.mant;
    lit_mant = swap ? op_x.mant    : op_y.mant;

    gap     = big_exp - lit_exp;
    gap_sat = (gap > EXP_W'(EXT_W)) ? SH_W'(EXT_W) : gap[SH_W-1:0];
    big_ext = {big_mant, {GRS_W{1'b0}}};
    lit_ext = {lit_mant, {GRS_W{1'b0}}};
    // lower half of the window collects everything shifted past the round bit
    shwin   = {lit_ext, {EXT_W{1'b0}}} >> gap_sat;
    lit_al  = shwin[2*EXT_W-1 -: EXT_W] | {{(EXT_W-1){1'b0}}, |shwin[EXT_W-1:0]};

    eff_sub = big_sign ^ lit_sign;
    mid.sum = eff_sub ? ({1'b0, big_ext} - {1'b0, lit_al})
                      : ({1'b0, big_ext} + {1'b0, lit_al});
    mid.exp_base  = big_exp;
    mid.sign      = big_sign;
    mid.zero_sign = op_x.sign & op_y.sign;

    any_nan   = op_x.is_nan | op_y.is_nan;
    inf_clash = op_x.is_inf & op_y.is_inf & (op_x.sign != op_y.sign);
    mid.special     = any_nan | op_x.is_inf | op_y.is_inf;
    mid.special_inv = !any_nan && inf_clash;
    if (any_nan || inf_clash)
      mid.special_word = QNAN_WORD;
    else if (op_x.is_inf)
      mid.special_word = {op_x.sign, EXP_MAX, {FRAC_W{1'b0}}};
    else
      mid.special_word = {op_y.sign, EXP_MAX, {FRAC_W{1'b0}}};
  end

  // R4: magnitude ordering keeps the effective subtraction non-negative
  always_comb begin
    assert_nonneg_R4: assert (!eff_sub || (big_ext >= lit_al));
  end
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round import fpadd_pkg::*; (
  input  mid_t              mid,
  output logic [WORD_W-1:0] word,
  output logic              ovf,
  output logic              udf,
  output logic              inv
);
  localparam int unsigned LZ_W = $clog2(EXT_W);
  localparam int unsigned E_W  = EXP_W + 2;

  logic [LZ_W-1:0]  lz;
  logic [E_W-1:0]   shl, e_work, e_fin, e_base;
  logic [EXT_W-1:0] norm;
  logic [MANT_W:0]  rnd;
  logic             up;

  // leading-zero count of the in-range part; the highest set bit wins
  always_comb begin
    lz = LZ_W'(EXT_W - 1);
    for (int i = 0; i < EXT_W; i++)
      if (mid.sum[i]) lz = LZ_W'(EXT_W - 1 - i);
  end

  always_comb begin
    e_base = E_W'(mid.exp_base);
    shl    = '0;
    if (mid.sum[EXT_W]) begin
      // carry out of the add: one step right, keep the lost bit sticky
      norm   = mid.sum[EXT_W:1] | {{(EXT_W-1){1'b0}}, mid.sum[0]};
      e_work = e_base + E_W'(1);
    end else begin
      // left shift stops at the minimum exponent, leaving a denormal
      shl    = (E_W'(lz) < e_base - E_W'(1)) ? E_W'(lz) : e_base - E_W'(1);
      norm   = mid.sum[EXT_W-1:0] << shl;
      e_work = e_base - shl;
    end

    // nearest, ties to even on guard / round / sticky
    up    = norm[GRS_W-1] & (norm[GRS_W-2] | norm[0] | norm[GRS_W]);
    rnd   = {1'b0, norm[EXT_W-1:GRS_W]} + (MANT_W+1)'(up);
    e_fin = e_work;
    if (rnd[MANT_W]) begin
      rnd   = rnd >> 1;
      e_fin = e_work + E_W'(1);
    end

    ovf = 1'b0;
    udf = 1'b0;
    inv = 1'b0;
    if (mid.special) begin
      word = mid.special_word;
      inv  = mid.special_inv;
    end else if (mid.sum == '0) begin
      word = {mid.zero_sign, {(WORD_W-1){1'b0}}};
    end else if (e_fin >= E_W'(EXP_MAX)) begin
      word = {mid.sign, EXP_MAX, {FRAC_W{1'b0}}};
      ovf  = 1'b1;
    end else if (!rnd[MANT_W-1]) begin
      word = {mid.sign, {EXP_W{1'b0}}, rnd[FRAC_W-1:0]};
      udf  = 1'b1;
    end else begin
      word = {mid.sign, e_fin[EXP_W-1:0], rnd[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp import fpadd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_sub,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_sum,
  output logic              out_ovf,
  output logic              out_udf,
  output logic              out_inv
);
  localparam int unsigned N_OPND = 2;

  logic [WORD_W-1:0] raw  [N_OPND];
  logic              flip [N_OPND];
  opnd_t             opnd [N_OPND];

  assign raw[0]  = in_a;
  assign raw[1]  = in_b;
  assign flip[0] = 1'b0;
  assign flip[1] = in_sub;

  for (genvar g = 0; g < N_OPND; g++) begin : g_unpack
    fpadd_unpack u_unpack (.word(raw[g]), .flip(flip[g]), .opnd(opnd[g]));
  end

  mid_t mid_c, s1_mid;
  fpadd_align u_align (.op_x(opnd[0]), .op_y(opnd[1]), .mid(mid_c));

  logic              s1_valid, s1_ready, s2_ready;
  logic [WORD_W-1:0] r_word;
  logic              r_ovf, r_udf, r_inv;

  fpadd_round u_round (.mid(s1_mid), .word(r_word), .ovf(r_ovf), .udf(r_udf), .inv(r_inv));

  // each stage advances when the stage after it is empty or draining
  assign s2_ready = !out_valid || out_ready;
  assign s1_ready = !s1_valid || s2_ready;
  assign in_ready = s1_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        s1_valid <= 1'b0;
    else if (s1_ready) s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_ready && in_valid) s1_mid <= mid_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (s2_ready) out_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s2_ready && s1_valid) begin
      out_sum <= r_word;
      out_ovf <= r_ovf;
      out_udf <= r_udf;
      out_inv <= r_inv;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) && $stable(out_ovf)
                                   && $stable(out_udf) && $stable(out_inv)));

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  assert_ovf_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_sum[WORD_W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}}));

  assert_flags_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_ovf, out_udf, out_inv}) <= 1));

  assert_inv_nan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv) |-> (out_sum == QNAN_WORD));

  assert_udf_den_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_udf) |-> ((out_sum[WORD_W-2 -: EXP_W] == '0)
                                && (out_sum[FRAC_W-1:0] != '0)));
endmodule

// File: tb/fpadd_sp_tb_top.sv
module fpadd_sp_tb_top;
  localparam int WIDE = 320;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sub, out_valid, out_ready;
  logic [31:0] in_a, in_b, out_sum;
  logic        out_ovf, out_udf, out_inv;

  always #4 clk = ~clk;

  fpadd_sp dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_ovf(out_ovf), .out_udf(out_udf), .out_inv(out_inv)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    lat_mode = 1'b0;
  bit    bp_on    = 1'b0;
  bit    done     = 1'b0;

  logic [31:0] exp_q  [$];
  logic [2:0]  flg_q  [$];
  string       tag_q  [$];
  int          acc_q  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // exact-arithmetic reference: wide integers, rounded once at the end
  function automatic void ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub,
                                  output logic [31:0] r, output logic [2:0] flg,
                                  output string tag);
    logic sa, sb, s, na, nb, ia, ib;
    logic [7:0] ea, eb;
    logic [22:0] fa, fb;
    logic [WIDE-1:0] ma, mb, mag, q, rem, half;
    int xa, xb, emin, p, e, sh;
    sa = a[31]; sb = b[31] ^ sub;
    ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
    r = 32'h0; flg = 3'b000; tag = "R4";
    na = (ea == 8'hFF) && (fa != 0); nb = (eb == 8'hFF) && (fb != 0);
    ia = (ea == 8'hFF) && (fa == 0); ib = (eb == 8'hFF) && (fb == 0);
    if (na || nb) begin r = 32'h7FC00000; tag = "R9"; return; end
    if (ia && ib) begin
      tag = "R10";
      if (sa != sb) begin r = 32'h7FC00000; flg = 3'b001; end
      else r = {sa, 8'hFF, 23'h0};
      return;
    end
    if (ia) begin r = {sa, 8'hFF, 23'h0}; tag = "R10"; return; end
    if (ib) begin r = {sb, 8'hFF, 23'h0}; tag = "R10"; return; end
    xa = (ea == 0) ? 1 : int'(ea);
    xb = (eb == 0) ? 1 : int'(eb);
    emin = (xa < xb) ? xa : xb;
    ma = WIDE'({(ea != 0), fa}) << (xa - emin);
    mb = WIDE'({(eb != 0), fb}) << (xb - emin);
    if ((ea == 0 && fa != 0) || (eb == 0 && fb != 0)) tag = "R6";
    else if ((xa - xb > 25) || (xb - xa > 25)) tag = "R5";
    if (sa == sb) begin mag = ma + mb; s = sa; end
    else if (ma >= mb) begin mag = ma - mb; s = sa; end
    else begin mag = mb - ma; s = sb; end
    if (mag == 0) begin r = {sa & sb, 31'h0}; tag = "R7"; return; end
    p = 0;
    for (int i = 0; i < WIDE; i++) if (mag[i]) p = i;
    e = p + emin - 23;
    if (e < 1) begin
      q = mag << (emin - 1);
      r = {s, 8'h00, q[22:0]}; flg = 3'b010; tag = "R6";
      return;
    end
    if (p > 23) begin
      sh   = p - 23;
      q    = mag >> sh;
      rem  = mag & ((WIDE'(1) << sh) - WIDE'(1));
      half = WIDE'(1) << (sh - 1);
      if (rem > half || (rem == half && q[0])) q = q + WIDE'(1);
    end else begin
      q = mag << (23 - p);
    end
    if (q[24]) begin q = q >> 1; e = e + 1; tag = "R11"; end
    if (e >= 255) begin r = {s, 8'hFF, 23'h0}; flg = 3'b100; tag = "R8"; return; end
    r = {s, e[7:0], q[22:0]};
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [31:0] r;
    logic [2:0]  f;
    string       t;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_sub = s;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    ref_add(a, b, s, r, f, t);
    exp_q.push_back(r); flg_q.push_back(f); tag_q.push_back(t); acc_q.push_back(cyc);
    @(posedge clk);
  endtask

  function automatic logic [31:0] pick_word(input logic [31:0] near);
    int unsigned k;
    logic [31:0] w;
    k = $urandom_range(0, 9);
    w = $urandom;
    case (k)
      0: w[30:23] = 8'h00;
      1: begin w[30:23] = 8'hFF; if ($urandom_range(0, 1) == 0) w[22:0] = 23'h0; end
      2: w[30:23] = 8'hFE;
      3, 4, 5, 6: w[30:23] = near[30:23] + 8'($urandom_range(0, 4)) - 8'd2;
      7: w[30:0] = near[30:0];
      default: ;
    endcase
    return w;
  endfunction

  task automatic send_random(input int n);
    logic [31:0] a;
    for (int i = 0; i < n; i++) begin
      a = pick_word($urandom);
      send(a, pick_word(a), 1'($urandom_range(0, 1)));
    end
  endtask

  task automatic drain();
    @(negedge clk); in_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // output monitor: samples in the low phase, well away from the rising edge
  logic [31:0] held_sum;
  logic [2:0]  held_flg;
  bit          hold_pending = 1'b0;
  always begin
    logic [31:0] e_r;
    logic [2:0]  e_f;
    string       e_t;
    int          e_c;
    @(negedge clk); #2;
    if (rst_n && !done) begin
      if (hold_pending) begin
        check(out_valid && out_sum == held_sum && {out_ovf, out_udf, out_inv} == held_flg,
              "R3", "held beat changed", out_sum, held_sum);
      end
      hold_pending = out_valid && !out_ready;
      held_sum = out_sum;
      held_flg = {out_ovf, out_udf, out_inv};
      if (out_ready)
        check(in_ready, "R2", "in_ready while out_ready", 32'(in_ready), 32'd1);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected result", out_sum, 32'h0);
        end else begin
          e_r = exp_q.pop_front(); e_f = flg_q.pop_front();
          e_t = tag_q.pop_front(); e_c = acc_q.pop_front();
          check(out_sum == e_r, e_t, "result (R1 order)", out_sum, e_r);
          check({out_ovf, out_udf, out_inv} == e_f, e_t, "flags ovf/udf/inv",
                32'({out_ovf, out_udf, out_inv}), 32'(e_f));
          if (lat_mode)
            check(cyc - e_c == 2, "R2", "latency", 32'(cyc - e_c), 32'd2);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_sub = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(!out_valid, "R12", "out_valid in reset", 32'(out_valid), 32'd0);
    check(in_ready, "R12", "in_ready in reset", 32'(in_ready), 32'd1);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(!out_valid, "R12", "out_valid after reset", 32'(out_valid), 32'd0);

    // phase 1: consumer always ready, exact latency checked
    out_ready = 1'b1; lat_mode = 1'b1;
    send(32'h3F800000, 32'h3F800000, 1'b0);   // R4 1 + 1
    send(32'h3F000000, 32'hBEE00000, 1'b0);   // R4 0.5 - 0.4375
    send(32'h3F800000, 32'h33800000, 1'b1);   // R4 1 - 2^-24
    send(32'h4B000000, 32'h3F000000, 1'b0);   // R5 tie to even, stays
    send(32'h4B000001, 32'h3F000000, 1'b0);   // R5 tie to even, goes up
    send(32'h3F800000, 32'h33800000, 1'b0);   // R5 exact half ulp
    send(32'h3F800000, 32'h33800001, 1'b0);   // R5 just above half
    send(32'h3F800000, 32'h0D800000, 1'b0);   // R5 far gap, sticky only
    send(32'h3FFFFFFF, 32'h33800000, 1'b0);   // R11 rounding carry
    send(32'h3F800000, 32'h00000001, 1'b0);   // R6 denormal operand
    send(32'h00000001, 32'h00000001, 1'b0);   // R6 denormal result
    send(32'h00400000, 32'h00400000, 1'b0);   // R6 denormals reach normal
    send(32'h00800000, 32'h00000001, 1'b1);   // R6 normal to denormal
    send(32'h3F800000, 32'h3F800000, 1'b1);   // R7 cancellation
    send(32'h80000000, 32'h80000000, 1'b0);   // R7 -0 + -0
    send(32'h80000000, 32'h00000000, 1'b1);   // R7 -0 - +0
    send(32'h00000000, 32'h80000000, 1'b0);   // R7 +0 + -0
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0);   // R8 overflow
    send(32'h7F7FFFFF, 32'h73000000, 1'b0);   // R8 overflow by rounding
    send(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1);   // R8 negative overflow
    send(32'h7FC00001, 32'h3F800000, 1'b0);   // R9 NaN in A
    send(32'h3F800000, 32'hFF800001, 1'b1);   // R9 NaN in B
    send(32'h7F800000, 32'h3F800000, 1'b0);   // R10 inf + finite
    send(32'h7F800000, 32'h7F800000, 1'b1);   // R10 inf - inf invalid
    send(32'hFF800000, 32'hFF800000, 1'b0);   // R10 same-sign infinities
    send(32'h3F800000, 32'h7F800000, 1'b1);   // R10 finite - inf
    send_random(600);
    drain();

    // phase 2: random back-pressure, ordering and holding checked
    lat_mode = 1'b0; bp_on = 1'b1;
    fork
      begin
        while (bp_on) begin
          @(negedge clk);
          out_ready = ($urandom_range(0, 2) != 0);
        end
        @(negedge clk);
        out_ready = 1'b1;
      end
    join_none
    send_random(600);
    @(negedge clk); in_valid = 1'b0; bp_on = 1'b0;
    drain();
    check(exp_q.size() == 0, "R1", "results outstanding", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule